// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Sequencer

This block is a clocked controller that performs one read or one write per request on an asynchronous DRAM. The DRAM has a shared row and column address bus and active-low row strobe, column strobe, write enable and output enable. A host presents a full word address, write data, a write flag and a timing-variant select. It holds a request until the sequencer is ready. The sequencer splits the address and walks the strobes through a fixed series of counted phases. It captures the returned word on reads and pulses done when the access is over.

Every timing quantity is a parameter expressed in controller clock cycles. These are row setup and hold, column setup, column hold, column access, row access, output-enable access, write pulse, precharge and full row cycle. Two strobe orderings exist for each access type. The early variants assert the direction strobe before the column strobe falls. The late variants assert it only after the column strobe has been low for the column hold count. The row cycle count is measured from one accepted request to the next. No new access can start before it runs out.

Top module: `dram_seq`

## Requirements
- R1: After reset, ready_o is 1, all four strobes are 1, dram_dq_en_o is 0, done_o is 0 and rdata_o is 0.
- R2: An accepted request puts its row (upper ROW_W address bits) on dram_a_o for T_ASR cycles with all strobes high. The row strobe then falls and the row stays on the bus for T_RAH cycles. The column (lower COL_W bits) is then on the bus for T_ASC cycles before the column strobe falls. The row strobe stays low until the column strobe rises, and the address is unchanged across each strobe fall.
- R3: Early read (we_i=0, late_i=0): OE is low from the start of the column phase. CAS stays low for max(T_CAC, T_RAC-T_RAH-T_ASC) cycles, and dram_dq_i is captured at the last edge of that window.
- R4: Late read (we_i=0, late_i=1): CAS is low for T_CAH cycles with OE high. OE then goes low for max(T_OEA, T_RAC-T_RAH-T_ASC-T_CAH) cycles with CAS still low, and data is captured at the last edge.
- R5: Early write (we_i=1, late_i=0): WE is low and the data bus is driven from the start of the column phase. CAS is low for T_WP cycles.
- R6: Late write (we_i=1, late_i=1): CAS is low for T_CAH cycles, then WE is low for T_WP cycles with CAS still low. Data is driven from the column phase until WE rises.
- R7: After each access, all strobes are high for T_RP cycles. done_o is a one-cycle pulse in the first of those cycles. On reads, rdata_o holds the captured word from that cycle until the next read capture, and writes leave it unchanged.
- R8: WE and OE are never low together. dram_dq_en_o is 1 only during writes and only while OE is high.
- R9: ready_o is 1 only when no access is in progress and at least T_RC cycles have passed since the previous acceptance edge. A request while ready_o is 0 has no effect.
- R10: Address, data, write flag and late select are sampled at acceptance. Changing them during an access has no effect on the strobes, bus or captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request, held until accepted |
| ready_o | output | 1 | Sequencer can accept a request this cycle |
| addr_i | input | ROW_W+COL_W | Word address, row in upper bits |
| we_i | input | 1 | 1 = write, 0 = read |
| late_i | input | 1 | 1 = late strobe ordering, 0 = early |
| wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-cycle access-complete pulse |
| rdata_o | output | DATA_W | Last captured read word |
| dram_a_o | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | DATA_W | Data driven to the DRAM |
| dram_dq_en_o | output | 1 | Drive enable for dram_dq_o (bus released when 0) |
| dram_dq_i | input | DATA_W | Data returned by the DRAM |

## Verification
All four access variants are run to the same and to different addresses. Read-after-write and an unwritten location show that data reaches the array and returns only through the selected ordering. The bench DRAM returns inverted junk until the row, column and output-enable access counts have run out, so a capture one edge early shows up as a wrong word. A request held high straight through an early read, whose sequence ends before the row cycle count expires, checks the ready spacing. Requests asserted mid-access and inputs inverted right after acceptance check that only the sampled values matter.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_RAS, ST_COL, ST_CAS, ST_LATE, ST_PRE
  } seq_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int T_ASR = 1,
  parameter int T_RAH = 2,
  parameter int T_ASC = 1,
  parameter int T_CAH = 2,
  parameter int T_WP  = 2,
  parameter int T_RP  = 3,
  parameter int D_ER  = 5,
  parameter int D_LR  = 3,
  parameter int CNT_W = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    we_i,
  input  logic    late_i,
  output seq_st_e state_o,
  output logic    capture_o,
  output logic    fin_enter_o
);
  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] dur;
  logic             phase_zero, adv;

  always_comb begin
    st_d = st_q;
    dur  = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin st_d = ST_ROW; dur = CNT_W'(T_ASR - 1); end
      ST_ROW:  begin st_d = ST_RAS; dur = CNT_W'(T_RAH - 1); end
      ST_RAS:  begin st_d = ST_COL; dur = CNT_W'(T_ASC - 1); end
      ST_COL: begin
        st_d = ST_CAS;
        if (late_i)    dur = CNT_W'(T_CAH - 1);
        else if (we_i) dur = CNT_W'(T_WP - 1);
        else           dur = CNT_W'(D_ER - 1);
      end
      ST_CAS: begin
        if (late_i) begin
          st_d = ST_LATE;
          dur  = we_i ? CNT_W'(T_WP - 1) : CNT_W'(D_LR - 1);
        end else begin
          st_d = ST_PRE;
          dur  = CNT_W'(T_RP - 1);
        end
      end
      ST_LATE: begin st_d = ST_PRE; dur = CNT_W'(T_RP - 1); end
      ST_PRE:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign adv = (st_q == ST_IDLE) ? start_i : phase_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  st_q <= ST_IDLE;
    else if (adv) st_q <= st_d;
  end

  dram_seq_timer #(.W(CNT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (adv),
    .val_i  (dur),
    .zero_o (phase_zero)
  );

  // capture on the last edge of the data-valid window
  assign capture_o   = phase_zero && !we_i &&
                       ((st_q == ST_CAS && !late_i) || st_q == ST_LATE);
  assign fin_enter_o = adv && (st_d == ST_PRE);
  assign state_o     = st_q;
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8,
  parameter int T_ASR  = 1,
  parameter int T_RAH  = 2,
  parameter int T_ASC  = 1,
  parameter int T_CAC  = 2,
  parameter int T_RAC  = 8,
  parameter int T_OEA  = 2,
  parameter int T_CAH  = 2,
  parameter int T_WP   = 2,
  parameter int T_RP   = 3,
  parameter int T_RC   = 14,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int A_W    = imax(ROW_W, COL_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              late_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [A_W-1:0]    dram_a_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_en_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  // stretch CAS / OE so that row access time is also met
  localparam int D_ER  = imax(T_CAC, T_RAC - T_RAH - T_ASC);
  localparam int D_LR  = imax(T_OEA, T_RAC - T_RAH - T_ASC - T_CAH);
  localparam int MAX_D = imax(imax(imax(T_ASR, T_RAH), imax(T_ASC, T_CAH)),
                              imax(imax(T_WP, T_RP), imax(D_ER, D_LR)));
  localparam int CNT_W = $clog2(MAX_D + 1);
  localparam int TRC_W = $clog2(T_RC + 1);

  seq_st_e           st;
  logic              accept, capture, fin_enter, trc_zero;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              we_q, late_q, done_q;
  logic              ras_low, col_ph, cas_low, dir_ph;

  assign ready_o = (st == ST_IDLE) && trc_zero;
  assign accept  = req_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      late_q <= 1'b0;
    end else if (accept) begin
      row_q  <= addr_i[ADDR_W-1:COL_W];
      col_q  <= addr_i[COL_W-1:0];
      wd_q   <= wdata_i;
      we_q   <= we_i;
      late_q <= late_i;
    end
  end

  dram_seq_fsm #(
    .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_CAH(T_CAH),
    .T_WP(T_WP), .T_RP(T_RP), .D_ER(D_ER), .D_LR(D_LR), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .we_i        (we_q),
    .late_i      (late_q),
    .state_o     (st),
    .capture_o   (capture),
    .fin_enter_o (fin_enter)
  );

  dram_seq_timer #(.W(TRC_W)) u_trc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .val_i  (TRC_W'(T_RC - 1)),
    .zero_o (trc_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_enter;
      if (capture) rd_q <= dram_dq_i;
    end
  end

  assign ras_low = st inside {ST_RAS, ST_COL, ST_CAS, ST_LATE};
  assign col_ph  = st inside {ST_COL, ST_CAS, ST_LATE};
  assign cas_low = st inside {ST_CAS, ST_LATE};
  assign dir_ph  = late_q ? (st == ST_LATE) : (st inside {ST_COL, ST_CAS});

  assign dram_a_o     = col_ph ? A_W'(col_q) : A_W'(row_q);
  assign dram_ras_no  = !ras_low;
  assign dram_cas_no  = !cas_low;
  assign dram_we_no   = !(we_q && dir_ph);
  assign dram_oe_no   = !(!we_q && dir_ph);
  assign dram_dq_o    = wd_q;
  assign dram_dq_en_o = we_q && col_ph;
  assign done_o       = done_q;
  assign rdata_o      = rd_q;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int DATA_W = 8,
  parameter int A_W    = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [A_W-1:0]    dram_a_o,
  input logic              dram_ras_no,
  input logic              dram_cas_no,
  input logic              dram_we_no,
  input logic              dram_oe_no,
  input logic              dram_dq_en_o
);
  p_oe_we_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dram_we_no && !dram_oe_no));
  p_dq_write_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_en_o |-> (dram_oe_no && !dram_ras_no));
  p_cas_in_ras_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  p_row_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> $stable(dram_a_o));
  p_col_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> $stable(dram_a_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dram_ras_no && dram_cas_no && dram_we_no && dram_oe_no));
  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);
  p_ready_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (dram_ras_no && !dram_dq_en_o && !done_o));
endmodule

bind dram_seq dram_seq_chk #(.DATA_W(DATA_W), .A_W(A_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .rdata_o      (rdata_o),
  .dram_a_o     (dram_a_o),
  .dram_ras_no  (dram_ras_no),
  .dram_cas_no  (dram_cas_no),
  .dram_we_no   (dram_we_no),
  .dram_oe_no   (dram_oe_no),
  .dram_dq_en_o (dram_dq_en_o)
);

// File: tb/dram_seq_tb.sv
`timescale 1ns/1ps
module dram_seq_tb;
  localparam int ROW_W = 9, COL_W = 9, DATA_W = 8, AW = ROW_W + COL_W;
  localparam int A_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_ASR = 1, T_RAH = 2, T_ASC = 1, T_CAC = 2, T_RAC = 8;
  localparam int T_OEA = 2, T_CAH = 2, T_WP = 2, T_RP = 3, T_RC = 14;
  localparam int D_ER = (T_CAC > T_RAC - T_RAH - T_ASC) ? T_CAC : T_RAC - T_RAH - T_ASC;
  localparam int D_LR = (T_OEA > T_RAC - T_RAH - T_ASC - T_CAH) ? T_OEA
                                                                : T_RAC - T_RAH - T_ASC - T_CAH;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, late = 0;
  logic [AW-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic ready_o, done_o, ras_n, cas_n, we_n, oe_n, dq_en;
  logic [DATA_W-1:0] rdata_o, dq_o, dq_i;
  logic [A_W-1:0] a_o;

  always #4 clk = ~clk;

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_ASR(T_ASR), .T_RAH(T_RAH),
    .T_ASC(T_ASC), .T_CAC(T_CAC), .T_RAC(T_RAC), .T_OEA(T_OEA), .T_CAH(T_CAH),
    .T_WP(T_WP), .T_RP(T_RP), .T_RC(T_RC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready_o), .addr_i(addr),
    .we_i(we), .late_i(late), .wdata_i(wdata), .done_o(done_o), .rdata_o(rdata_o),
    .dram_a_o(a_o), .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_oe_no(oe_n), .dram_dq_o(dq_o), .dram_dq_en_o(dq_en), .dram_dq_i(dq_i)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural DRAM ----------------
  logic [DATA_W-1:0] dmem [int];
  logic [ROW_W-1:0]  drow = '0;
  int ras_cnt = 0, cas_cnt = 0, oe_cnt = 0, ov = 0;

  function automatic logic [DATA_W-1:0] dread(input int idx);
    return dmem.exists(idx) ? dmem[idx] : '0;
  endfunction

  wire [AW-1:0] dcell = {drow, a_o[COL_W-1:0]};
  wire dvalid = !ras_n && !cas_n && !oe_n && ras_cnt >= T_RAC - 1 &&
                cas_cnt >= T_CAC - 1 && oe_cnt >= T_OEA - 1;
  assign dq_i = dvalid ? dread(int'(dcell)) : ~dread(int'(dcell));

  always @(posedge clk) begin
    if (!ras_n && ras_cnt == 0) drow <= a_o[ROW_W-1:0];
    ras_cnt <= ras_n ? 0 : ras_cnt + 1;
    cas_cnt <= cas_n ? 0 : cas_cnt + 1;
    oe_cnt  <= oe_n  ? 0 : oe_cnt + 1;
    if (!we_n && !cas_n && !ras_n) begin
      if (rst_n) chk(dq_en, "R8", dq_en, 1);
      dmem[int'(dcell)] = dq_o;
      ov <= ov + 1;
    end else if (ov != 0) begin
      chk(ov >= T_WP, "R5 R6 write pulse", ov, T_WP);
      ov <= 0;
    end
  end

  // ---------------- reference model ----------------
  logic [DATA_W-1:0] ref_mem [int];
  bit active = 0, m_we = 0, m_late = 0;
  int k = 0, age = T_RC, b0, b1, b2, b3, b4, b5;
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;
  logic [DATA_W-1:0] m_wd = '0, exp_rd = '0;
  string m_tag = "R9";

  function automatic bit exp_ready();
    return !active && age >= T_RC - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 0; k <= 0; age <= T_RC; m_row <= '0; m_col <= '0;
      m_we <= 0; m_late <= 0; m_wd <= '0; exp_rd <= '0;
    end else begin
      bit acc;
      int d1, d2;
      acc = req && exp_ready();
      if (age < T_RC) age <= age + 1;
      if (active) begin
        if (k == b4 - 1 && !m_we)
          exp_rd <= ref_mem.exists(int'({m_row, m_col})) ? ref_mem[int'({m_row, m_col})] : '0;
        if (k + 1 >= b5) active <= 0;
        k <= k + 1;
      end
      if (acc) begin
        active <= 1; k <= 0; age <= 0;
        m_row <= addr[AW-1:COL_W]; m_col <= addr[COL_W-1:0];
        m_we <= we; m_late <= late; m_wd <= wdata;
        if (we) ref_mem[int'(addr)] = wdata;
        d1 = late ? T_CAH : (we ? T_WP : D_ER);
        d2 = late ? (we ? T_WP : D_LR) : 0;
        b0 <= T_ASR; b1 <= T_ASR + T_RAH; b2 <= T_ASR + T_RAH + T_ASC;
        b3 <= T_ASR + T_RAH + T_ASC + d1; b4 <= T_ASR + T_RAH + T_ASC + d1 + d2;
        b5 <= T_ASR + T_RAH + T_ASC + d1 + d2 + T_RP;
        m_tag <= we ? (late ? "R6" : "R5") : (late ? "R4" : "R3");
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit in_ras, in_col, in_cas, in_dir, e_oe, e_we, e_dq;
      logic [A_W-1:0] e_a;
      string tg;
      tg     = active ? m_tag : "R9";
      in_ras = active && k >= b0 && k < b4;
      in_col = active && k >= b1 && k < b4;
      in_cas = active && k >= b2 && k < b4;
      in_dir = active && (m_late ? (k >= b3 && k < b4) : (k >= b1 && k < b3));
      e_oe   = in_dir && !m_we;
      e_we   = in_dir && m_we;
      e_dq   = in_col && m_we;
      e_a    = in_col ? A_W'(m_col) : A_W'(m_row);
      chk(ready_o == exp_ready(), "R9 ready", ready_o, exp_ready());
      chk(ras_n == !in_ras, "R2 ras", ras_n, !in_ras);
      chk(cas_n == !in_cas, "R2 cas", cas_n, !in_cas);
      chk(a_o == e_a, "R2 R10 address", a_o, e_a);
      chk(oe_n == !e_oe, {tg, " oe"}, oe_n, !e_oe);
      chk(we_n == !e_we, {tg, " we"}, we_n, !e_we);
      chk(dq_en == e_dq, {tg, " R8 dq_en"}, dq_en, e_dq);
      if (dq_en) chk(dq_o == m_wd, "R10 write data", dq_o, m_wd);
      chk(!(!we_n && !oe_n), "R8 we/oe overlap", {we_n, oe_n}, 2'b11);
      chk(done_o == (active && k == b4), "R7 done", done_o, active && k == b4);
      chk(rdata_o == exp_rd, "R7 R10 rdata", rdata_o, exp_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [AW-1:0] ad, input bit w, input bit lt,
                       input logic [DATA_W-1:0] d, input bit poke);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1; addr = ad; we = w; late = lt; wdata = d;
    @(negedge clk);
    req = 0; addr = ~ad; we = !w; late = !lt; wdata = ~d;  // R10: inputs change mid-access
    if (poke) begin
      req = 1;                                               // R9: request while busy
      repeat (3) @(negedge clk);
      req = 0;
    end
    while (!done_o) @(negedge clk);
  endtask

  task automatic back_to_back(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                              input logic [DATA_W-1:0] d2);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1; addr = a1; we = 0; late = 0; wdata = '0;
    @(negedge clk);
    addr = a2; we = 1; late = 0; wdata = d2;  // held high: R9 spacing
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    req = 0;
    while (!done_o) @(negedge clk);
  endtask

  localparam logic [AW-1:0] AD_A = 18'h2A0F5, AD_B = 18'h0C3A6, AD_C = 18'h13579;
  localparam logic [AW-1:0] AD_F = 18'h3FFFF;

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    chk(ready_o == 1, "R1 ready", ready_o, 1);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(dq_en == 0 && done_o == 0, "R1 dq_en/done", {dq_en, done_o}, 0);
    chk(rdata_o == 0, "R1 rdata", rdata_o, 0);
    rst_n = 1;
    issue(AD_A, 1, 0, 8'h5A, 0);   // R5
    issue(AD_A, 0, 0, 8'h00, 0);   // R3
    issue(AD_B, 1, 1, 8'hC3, 0);   // R6
    issue(AD_B, 0, 1, 8'h00, 0);   // R4
    issue(AD_A, 0, 1, 8'h00, 1);   // R4, R9 busy request
    issue(AD_B, 0, 0, 8'h00, 0);   // R3
    issue(AD_C, 0, 0, 8'h00, 0);   // R3 unwritten cell
    issue(AD_F, 1, 1, 8'h81, 1);   // R6, R9 busy request
    issue(AD_F, 0, 0, 8'h00, 0);   // R3
    issue(AD_C, 1, 0, 8'h3C, 0);   // R5, R7 rdata unchanged by write
    back_to_back(AD_A, AD_B, 8'hE7);
    issue(AD_B, 0, 1, 8'h00, 0);   // R4 reads back-to-back write
    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule